// File: doc/BRIEF.md
# Hub Downstream Port State Controller

This block holds the per-port state of the five downstream ports of a USB hub. Ports 1 to 4 lead to external connectors, and port 5 is wired permanently to an embedded function. Firmware changes a port's state by writing one byte. That byte carries an action code and the number of the port it applies to. The block keeps these flags for every port:

- enabled
- suspended
- in reset
- powered
- low-speed device attached

At the frame's EOF2 point it also records the D+ and D- line levels of each port.

Hardware events set a small change register for each port. These events are a connect or disconnect, the end of a port reset, and the end of a resume. Firmware clears these bits by writing ones to them. An eight-bit summary shows which ports have any change pending. A separate monitor raises a global-suspend flag once the upstream bus has been idle for long enough.

All timing is counted in pulses of a slow tick strobe, which is normally 1 ms. The port reset length, the delay before the embedded port is enabled again after a resume, and the idle time before global suspend are all parameters. Transceivers, the repeater and overcurrent sensing are outside the block. They reach it only as strobes and level inputs.

Top module: `hub_port_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every per-port flag, every change register, the summary and the global-suspend flag are zero.
- R2: A command write decodes `cmd_data[6:4]` as the action and `cmd_data[2:0]` as the port address, with 001 to 101 selecting ports 1 to 5. The actions are:
  - 010 sets the port's enable flag.
  - 001 clears the port's enable flag.
  - 110 sets the port's power flag.
  
  Each action takes effect at the next clock edge.
- R3: A command with action 000 or 111, or with port address 000, 110 or 111, changes no port state.
- R4: Action 011 sets the suspend flag. Action 100 on ports 1 to 4 clears the suspend flag and sets change bit 2 (suspend change), both at the next edge.
- R5: Action 101 sets the port's reset flag and clears its enable flag. The reset flag stays high until RST_TICKS tick pulses have been counted.
- R6: The edge that counts the last reset tick does three things together: it clears the reset flag, sets the enable flag and sets change bit 4 (reset change).
- R7: Action 100 on port 5 clears its suspend flag at once. Its enable flag and change bit 2 are set only on the edge that counts the RESUME_TICKS-th tick, and not earlier.
- R8: A change-register write clears each of bits 0, 2 and 4 for which the data bit is 1; bits written as 0 are left unchanged. Bit 3 (overcurrent change) takes the written value. A hardware set in the same cycle wins over a clear.
- R9: Summary bit n-1 is 1 exactly when port n has any change bit set. Summary bits 7 to 5 read as zero.
- R10: The low-speed flag and the captured line levels change only on a cycle with the EOF2 strobe. Port 1 always reports full speed, meaning its low-speed flag is 0.
- R11: The global-suspend flag rises after IDLE_TICKS tick pulses of continuous bus idle. It stays high while the bus remains idle and falls on the first cycle without idle.
- R12: A connect-event strobe on a port sets its change bit 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Action in [6:4], port address in [2:0] |
| chg_wr | input | 1 | Change-register write strobe |
| chg_sel | input | 3 | Port addressed by the change write (1 to 5) |
| chg_data | input | 8 | Change write data (ones clear bits 0, 2, 4; bit 3 written directly) |
| rd_sel | input | 3 | Port whose change register appears on rd_chg |
| rd_chg | output | 8 | Change register of the selected port, or zero for an invalid address |
| tick | input | 1 | Time-base strobe, one cycle wide |
| eof2 | input | 1 | EOF2 frame-point strobe |
| ls_attach | input | 5 | Raw low-speed detect per port |
| line_dp | input | 5 | D+ line level per port |
| line_dm | input | 5 | D- line level per port |
| conn_evt | input | 5 | Connect or disconnect event strobe per port |
| bus_idle | input | 1 | Upstream bus idle level |
| port_en | output | 5 | Enable flag per port |
| port_susp | output | 5 | Suspend flag per port |
| port_rst | output | 5 | Reset-in-progress flag per port |
| port_pwr | output | 5 | Power flag per port |
| port_ls | output | 5 | Low-speed attached flag per port |
| cap_dp | output | 5 | D+ level captured at EOF2 |
| cap_dm | output | 5 | D- level captured at EOF2 |
| chg_summary | output | 8 | Per-port change summary |
| glob_susp | output | 1 | Global suspend flag |

## Verification
Most of the state is visible directly on the ports. The flags, the summary and the selected change register all update on the edge after their cause, so a wrong value in one of them appears at the next sample. The tick counters are hidden, and an off-by-one error in one of them shows only as a change of timing. A reset, a port-5 resume or a suspend that completes one tick early or late would appear as a flag and a change bit moving at the wrong tick. For this reason the bench samples on the tick before each expected completion as well as on the completing tick. A decode that is wrong for one port or one action shows as a flag moving on the wrong port. The bench looks for this by comparing all five ports after every command.

// File: rtl/hub_port_pkg.sv
// Shared types for the hub downstream port controller.
// Assumes a 3-bit action field and a 3-bit port address in the command byte.
package hub_port_pkg;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'b000,
        ACT_DISABLE = 3'b001,
        ACT_ENABLE  = 3'b010,
        ACT_SUSPEND = 3'b011,
        ACT_RESUME  = 3'b100,
        ACT_RESET   = 3'b101,
        ACT_POWER   = 3'b110,
        ACT_RSVD    = 3'b111
    } port_act_e;

    // Change-register bit positions
    localparam int CHG_CONN = 0;
    localparam int CHG_SUSP = 2;
    localparam int CHG_OVC  = 3;
    localparam int CHG_RST  = 4;

    // One-cycle operation strobes delivered to a single port
    typedef struct packed {
        logic dis;
        logic en;
        logic susp;
        logic res;
        logic rst;
        logic pwr;
    } port_op_t;

endpackage

// File: rtl/hub_cmd_decode.sv
// Decodes a firmware command byte into per-port operation strobes.
// Assumes: at most one port is addressed per write; unknown actions and
// addresses outside 1..NPORT produce no strobe.
module hub_cmd_decode
    import hub_port_pkg::*;
#(
    parameter int NPORT = 5
) (
    input  logic                   cmd_wr,
    input  logic [7:0]             cmd_data,
    output port_op_t [NPORT-1:0]   op_vec
);

    port_act_e  act;
    logic [2:0] addr;
    logic       unused_cmd_bits;

    assign act             = port_act_e'(cmd_data[6:4]);
    assign addr            = cmd_data[2:0];
    assign unused_cmd_bits = cmd_data[7] ^ cmd_data[3];

    // Route the action strobe to the addressed port only
    always_comb begin
        op_vec = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (cmd_wr && addr == 3'(i + 1)) begin
                unique case (act)
                    ACT_DISABLE: op_vec[i].dis  = 1'b1;
                    ACT_ENABLE:  op_vec[i].en   = 1'b1;
                    ACT_SUSPEND: op_vec[i].susp = 1'b1;
                    ACT_RESUME:  op_vec[i].res  = 1'b1;
                    ACT_RESET:   op_vec[i].rst  = 1'b1;
                    ACT_POWER:   op_vec[i].pwr  = 1'b1;
                    default:     ;
                endcase
            end
        end
    end

endmodule

// File: rtl/hub_port_slot.sv
// State of one downstream port: flags, reset and resume timers, EOF2 capture
// and the change register.
// Assumes: tick is a one-cycle strobe; RST_TICKS and RESUME_TICKS are >= 1.
// FULL_ONLY forces full speed; DELAYED_RESUME selects the timed resume.
module hub_port_slot
    import hub_port_pkg::*;
#(
    parameter int RST_TICKS      = 10,
    parameter int RESUME_TICKS   = 23,
    parameter bit FULL_ONLY      = 1'b0,
    parameter bit DELAYED_RESUME = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  port_op_t   op,
    input  logic       tick,
    input  logic       eof2,
    input  logic       ls_in,
    input  logic       dp_in,
    input  logic       dm_in,
    input  logic       conn_evt,
    input  logic       chg_wr,
    input  logic [7:0] chg_data,
    output logic       en,
    output logic       susp,
    output logic       rst_act,
    output logic       pwr,
    output logic       ls,
    output logic       dp,
    output logic       dm,
    output logic [7:0] chg
);

    localparam int RCW = $clog2(RST_TICKS + 1);

    logic [RCW-1:0] rst_cnt;
    logic           rst_done;
    logic           res_pend;
    logic           res_done;
    logic           c_conn, c_susp, c_ovc, c_rst;
    logic           unused_wdata;

    assign unused_wdata = ^{chg_data[7:5], chg_data[1]};
    assign rst_done     = rst_act && tick && (rst_cnt == RCW'(1)) && !op.rst;

    // Timed resume variant for the embedded port, immediate variant otherwise
    generate
        if (DELAYED_RESUME) begin : g_timed
            localparam int DCW = $clog2(RESUME_TICKS + 1);
            logic [DCW-1:0] res_cnt;
            logic           pend_q;

            assign res_pend = pend_q;
            assign res_done = pend_q && tick && (res_cnt == DCW'(1)) && !op.rst;

            // Count resume ticks; a reset command cancels the wait
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q  <= 1'b0;
                    res_cnt <= '0;
                end else if (op.rst) begin
                    pend_q  <= 1'b0;
                    res_cnt <= '0;
                end else if (op.res) begin
                    pend_q  <= 1'b1;
                    res_cnt <= DCW'(RESUME_TICKS);
                end else if (pend_q && tick) begin
                    if (res_cnt == DCW'(1)) pend_q <= 1'b0;
                    res_cnt <= res_cnt - DCW'(1);
                end
            end
        end else begin : g_immediate
            assign res_pend = 1'b0;
            assign res_done = op.res;
        end
    endgenerate

    // Enable, suspend, power and reset flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            susp    <= 1'b0;
            pwr     <= 1'b0;
            rst_act <= 1'b0;
            rst_cnt <= '0;
        end else begin
            if (op.dis) en <= 1'b0;
            if (op.en && !rst_act && !res_pend) en <= 1'b1;
            if (op.pwr) pwr <= 1'b1;
            if (op.susp) susp <= 1'b1;
            if (op.res) susp <= 1'b0;
            if (DELAYED_RESUME && res_done) en <= 1'b1;
            if (op.rst) begin
                rst_act <= 1'b1;
                en      <= 1'b0;
                susp    <= 1'b0;
                rst_cnt <= RCW'(RST_TICKS);
            end else if (rst_act && tick) begin
                if (rst_done) begin
                    rst_act <= 1'b0;
                    en      <= 1'b1;
                end
                rst_cnt <= rst_cnt - RCW'(1);
            end
        end
    end

    // Line state and speed capture at the EOF2 frame point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls <= 1'b0;
            dp <= 1'b0;
            dm <= 1'b0;
        end else if (eof2) begin
            ls <= FULL_ONLY ? 1'b0 : ls_in;
            dp <= dp_in;
            dm <= dm_in;
        end
    end

    // Change bits: hardware sets, firmware clears by writing ones; a set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_conn <= 1'b0;
            c_susp <= 1'b0;
            c_ovc  <= 1'b0;
            c_rst  <= 1'b0;
        end else begin
            if (conn_evt)                          c_conn <= 1'b1;
            else if (chg_wr && chg_data[CHG_CONN]) c_conn <= 1'b0;
            if (res_done)                          c_susp <= 1'b1;
            else if (chg_wr && chg_data[CHG_SUSP]) c_susp <= 1'b0;
            if (rst_done)                          c_rst  <= 1'b1;
            else if (chg_wr && chg_data[CHG_RST])  c_rst  <= 1'b0;
            if (chg_wr)                            c_ovc  <= chg_data[CHG_OVC];
        end
    end

    assign chg = {3'b000, c_rst, c_ovc, c_susp, 1'b0, c_conn};

    // R5: a port in reset is never enabled
    a_r5_rst_not_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |-> !en);

    // R6: leaving reset enables the port and flags the reset change
    a_r6_rst_completion: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_act) |-> (en && chg[CHG_RST]));

    // R2: an accepted enable command takes effect on the next edge
    a_r2_enable_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (op.en && !rst_act && !res_pend && !op.rst) |=> en);

    // R4: a resume command clears suspend on the next edge
    a_r4_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
        op.res |=> !susp);

    // R10: speed flag holds between EOF2 strobes
    a_r10_ls_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !eof2 |=> $stable(ls));

    // R12: a connect event is always recorded
    a_r12_conn_sets: assert property (@(posedge clk) disable iff (!rst_n)
        conn_evt |=> chg[CHG_CONN]);

    // R8: a one written to bit 0 clears it absent a new event
    a_r8_w1c_conn: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_wr && chg_data[CHG_CONN] && !conn_evt) |=> !chg[CHG_CONN]);

endmodule

// File: rtl/hub_idle_mon.sv
// Global suspend detector: counts tick pulses of continuous bus idle.
// Assumes tick is a one-cycle strobe and IDLE_TICKS >= 1.
module hub_idle_mon #(
    parameter int IDLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bus_idle,
    output logic glob_susp
);

    localparam int ICW = $clog2(IDLE_TICKS + 1);

    logic [ICW-1:0] idle_cnt;

    // Count idle ticks, flag suspend at the limit, drop on any activity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt  <= '0;
            glob_susp <= 1'b0;
        end else if (!bus_idle) begin
            idle_cnt  <= '0;
            glob_susp <= 1'b0;
        end else if (tick && idle_cnt != ICW'(IDLE_TICKS)) begin
            idle_cnt <= idle_cnt + ICW'(1);
            if (idle_cnt == ICW'(IDLE_TICKS - 1)) glob_susp <= 1'b1;
        end
    end

    // R11: suspend holds while the bus stays idle
    a_r11_susp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_susp && bus_idle) |=> glob_susp);

    // R11: activity drops suspend on the next edge
    a_r11_activity_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_idle |=> !glob_susp);

    // R11: suspend never rises without idle
    a_r11_rise_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glob_susp) |-> $past(bus_idle));

endmodule

// File: rtl/hub_port_ctrl.sv
// Top of the hub downstream port controller: command decode, one state slot
// per port (port 1 full speed only, last port with timed resume), change
// register read mux and summary, and the global suspend monitor.
// Assumes NPORT <= 7 so that every port fits the 3-bit address field.
module hub_port_ctrl
    import hub_port_pkg::*;
#(
    parameter int NPORT        = 5,
    parameter int RST_TICKS    = 10,
    parameter int RESUME_TICKS = 23,
    parameter int IDLE_TICKS   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_data,
    input  logic             chg_wr,
    input  logic [2:0]       chg_sel,
    input  logic [7:0]       chg_data,
    input  logic [2:0]       rd_sel,
    output logic [7:0]       rd_chg,
    input  logic             tick,
    input  logic             eof2,
    input  logic [NPORT-1:0] ls_attach,
    input  logic [NPORT-1:0] line_dp,
    input  logic [NPORT-1:0] line_dm,
    input  logic [NPORT-1:0] conn_evt,
    input  logic             bus_idle,
    output logic [NPORT-1:0] port_en,
    output logic [NPORT-1:0] port_susp,
    output logic [NPORT-1:0] port_rst,
    output logic [NPORT-1:0] port_pwr,
    output logic [NPORT-1:0] port_ls,
    output logic [NPORT-1:0] cap_dp,
    output logic [NPORT-1:0] cap_dm,
    output logic [7:0]       chg_summary,
    output logic             glob_susp
);

    port_op_t [NPORT-1:0]       op_vec;
    logic     [NPORT-1:0][7:0]  chg_arr;
    logic     [NPORT-1:0]       any_chg;

    hub_cmd_decode #(.NPORT(NPORT)) i_decode (
        .cmd_wr   (cmd_wr),
        .cmd_data (cmd_data),
        .op_vec   (op_vec)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            hub_port_slot #(
                .RST_TICKS      (RST_TICKS),
                .RESUME_TICKS   (RESUME_TICKS),
                .FULL_ONLY      (p == 0),
                .DELAYED_RESUME (p == NPORT - 1)
            ) i_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .op       (op_vec[p]),
                .tick     (tick),
                .eof2     (eof2),
                .ls_in    (ls_attach[p]),
                .dp_in    (line_dp[p]),
                .dm_in    (line_dm[p]),
                .conn_evt (conn_evt[p]),
                .chg_wr   (chg_wr && chg_sel == 3'(p + 1)),
                .chg_data (chg_data),
                .en       (port_en[p]),
                .susp     (port_susp[p]),
                .rst_act  (port_rst[p]),
                .pwr      (port_pwr[p]),
                .ls       (port_ls[p]),
                .dp       (cap_dp[p]),
                .dm       (cap_dm[p]),
                .chg      (chg_arr[p])
            );
            assign any_chg[p] = |chg_arr[p];
        end
    endgenerate

    // Summary: one bit per port, upper bits zero
    always_comb begin
        chg_summary              = '0;
        chg_summary[NPORT-1:0]   = any_chg;
    end

    // Change register read mux by port address
    always_comb begin
        rd_chg = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (rd_sel == 3'(i + 1)) rd_chg = chg_arr[i];
        end
    end

    hub_idle_mon #(.IDLE_TICKS(IDLE_TICKS)) i_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_idle  (bus_idle),
        .glob_susp (glob_susp)
    );

    // R10: port 1 never reports low speed
    a_r10_port1_full_speed: assert property (@(posedge clk) disable iff (!rst_n)
        eof2 |=> !port_ls[0]);

endmodule

// File: tb/test_hub_port_ctrl.sv
module test_hub_port_ctrl;

    localparam int B_RST  = 4;
    localparam int B_RES  = 23;
    localparam int B_IDLE = 3;

    localparam int O_EN = 0, O_SUSP = 1, O_RST = 2, O_PWR = 3, O_LS = 4,
                   O_DP = 5, O_DM = 6, O_SUM = 7, O_RD = 8, O_GS = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       chg_wr = 1'b0;
    logic [2:0] chg_sel = '0;
    logic [7:0] chg_data = '0;
    logic [2:0] rd_sel = '0;
    logic [7:0] rd_chg;
    logic       tick = 1'b0;
    logic       eof2 = 1'b0;
    logic [4:0] ls_attach = '0, line_dp = '0, line_dm = '0, conn_evt = '0;
    logic       bus_idle = 1'b0;
    logic [4:0] port_en, port_susp, port_rst, port_pwr, port_ls, cap_dp, cap_dm;
    logic [7:0] chg_summary;
    logic       glob_susp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string      req;
        int         obs;
        logic [7:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    hub_port_ctrl #(
        .NPORT(5), .RST_TICKS(B_RST), .RESUME_TICKS(B_RES), .IDLE_TICKS(B_IDLE)
    ) i_hub_port_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .chg_wr(chg_wr), .chg_sel(chg_sel), .chg_data(chg_data),
        .rd_sel(rd_sel), .rd_chg(rd_chg), .tick(tick), .eof2(eof2),
        .ls_attach(ls_attach), .line_dp(line_dp), .line_dm(line_dm),
        .conn_evt(conn_evt), .bus_idle(bus_idle), .port_en(port_en),
        .port_susp(port_susp), .port_rst(port_rst), .port_pwr(port_pwr),
        .port_ls(port_ls), .cap_dp(cap_dp), .cap_dm(cap_dm),
        .chg_summary(chg_summary), .glob_susp(glob_susp)
    );

    function automatic logic [7:0] observe(int obs);
        case (obs)
            O_EN:    return {3'b0, port_en};
            O_SUSP:  return {3'b0, port_susp};
            O_RST:   return {3'b0, port_rst};
            O_PWR:   return {3'b0, port_pwr};
            O_LS:    return {3'b0, port_ls};
            O_DP:    return {3'b0, cap_dp};
            O_DM:    return {3'b0, cap_dm};
            O_SUM:   return chg_summary;
            O_RD:    return rd_chg;
            default: return {7'b0, glob_susp};
        endcase
    endfunction

    // Monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (observe(it.obs) !== it.exp) begin
                    fails++;
                    $display("FAIL %s obs=%0d actual=%02h expected=%02h",
                             it.req, it.obs, observe(it.obs), it.exp);
                end
            end
        end
    end

    task automatic expect_v(string req, int obs, logic [7:0] exp);
        sb_q.push_back('{req, obs, exp});
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_cmd(logic [2:0] act, logic [2:0] addr);
        cyc();
        cmd_wr = 1'b1; cmd_data = {1'b0, act, 1'b0, addr};
        cyc();
        cmd_wr = 1'b0; cmd_data = '0;
    endtask

    task automatic do_chg(logic [2:0] port, logic [7:0] data);
        cyc();
        chg_wr = 1'b1; chg_sel = port; chg_data = data;
        cyc();
        chg_wr = 1'b0; chg_data = '0;
    endtask

    task automatic do_tick();
        cyc();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        expect_v("R1 en", O_EN, 8'h00);
        expect_v("R1 susp", O_SUSP, 8'h00);
        expect_v("R1 rst", O_RST, 8'h00);
        expect_v("R1 pwr", O_PWR, 8'h00);
        expect_v("R1 summary", O_SUM, 8'h00);
        expect_v("R1 gsusp", O_GS, 8'h00);

        // R2: power and enable decode
        do_cmd(3'b110, 3'd2);
        expect_v("R2 power port2", O_PWR, 8'h02);
        do_cmd(3'b010, 3'd1);
        do_cmd(3'b010, 3'd3);
        expect_v("R2 enable ports1,3", O_EN, 8'h05);

        // R3: ignored codes and addresses
        do_cmd(3'b111, 3'd4);
        do_cmd(3'b000, 3'd4);
        do_cmd(3'b010, 3'd6);
        do_cmd(3'b110, 3'd0);
        expect_v("R3 en unchanged", O_EN, 8'h05);
        expect_v("R3 pwr unchanged", O_PWR, 8'h02);
        expect_v("R3 susp unchanged", O_SUSP, 8'h00);
        expect_v("R3 rst unchanged", O_RST, 8'h00);

        do_cmd(3'b001, 3'd1);
        expect_v("R2 disable port1", O_EN, 8'h04);

        // R5/R6: reset of port 2
        do_cmd(3'b101, 3'd2);
        expect_v("R5 rst set", O_RST, 8'h02);
        for (int k = 0; k < B_RST - 1; k++) do_tick();
        expect_v("R5 rst held", O_RST, 8'h02);
        expect_v("R5 en low in reset", O_EN, 8'h04);
        do_tick();
        rd_sel = 3'd2;
        expect_v("R6 rst done", O_RST, 8'h00);
        expect_v("R6 en set", O_EN, 8'h06);
        expect_v("R6 rst change", O_RD, 8'h10);
        expect_v("R9 summary port2", O_SUM, 8'h02);

        // R8: write-one-to-clear
        do_chg(3'd2, 8'h10);
        expect_v("R8 w1c bit4", O_RD, 8'h00);
        expect_v("R9 summary clear", O_SUM, 8'h00);

        // R8: overcurrent bit written directly
        do_chg(3'd4, 8'h08);
        rd_sel = 3'd4;
        expect_v("R8 ovc write", O_RD, 8'h08);
        expect_v("R9 summary port4", O_SUM, 8'h08);
        do_chg(3'd4, 8'h00);
        expect_v("R8 ovc clear", O_RD, 8'h00);

        // R4: suspend/resume on port 3
        do_cmd(3'b011, 3'd3);
        expect_v("R4 suspend", O_SUSP, 8'h04);
        do_cmd(3'b100, 3'd3);
        rd_sel = 3'd3;
        expect_v("R4 resume clears", O_SUSP, 8'h00);
        expect_v("R4 susp change", O_RD, 8'h04);
        expect_v("R9 summary port3", O_SUM, 8'h04);
        do_chg(3'd3, 8'h04);
        expect_v("R8 clear bit2", O_SUM, 8'h00);

        // R7: timed resume of port 5
        do_cmd(3'b011, 3'd5);
        expect_v("R7 suspend port5", O_SUSP, 8'h10);
        do_cmd(3'b100, 3'd5);
        rd_sel = 3'd5;
        expect_v("R7 susp cleared", O_SUSP, 8'h00);
        expect_v("R7 not yet enabled", O_EN, 8'h06);
        for (int k = 0; k < B_RES - 1; k++) do_tick();
        expect_v("R7 en still low", O_EN, 8'h06);
        expect_v("R7 no change yet", O_RD, 8'h00);
        do_tick();
        expect_v("R7 enabled", O_EN, 8'h16);
        expect_v("R7 susp change", O_RD, 8'h04);
        expect_v("R9 summary port5", O_SUM, 8'h10);
        do_chg(3'd5, 8'h04);

        // R10: EOF2 capture
        cyc();
        ls_attach = 5'b11111; line_dp = 5'b10101; line_dm = 5'b01010;
        cyc();
        expect_v("R10 ls held", O_LS, 8'h00);
        expect_v("R10 dp held", O_DP, 8'h00);
        eof2 = 1'b1;
        cyc();
        eof2 = 1'b0;
        expect_v("R10 ls captured, port1 full", O_LS, 8'h1E);
        expect_v("R10 dp captured", O_DP, 8'h15);
        expect_v("R10 dm captured", O_DM, 8'h0A);

        // R12: connect event, and R8 writing other bits leaves bit0
        conn_evt = 5'b00001;
        cyc();
        conn_evt = '0;
        rd_sel = 3'd1;
        expect_v("R12 conn change", O_RD, 8'h01);
        expect_v("R9 summary port1", O_SUM, 8'h01);
        do_chg(3'd1, 8'h10);
        expect_v("R8 other bit no effect", O_RD, 8'h01);
        do_chg(3'd1, 8'h01);
        expect_v("R8 clear bit0", O_RD, 8'h00);

        // R11: global suspend
        cyc();
        bus_idle = 1'b1;
        for (int k = 0; k < B_IDLE - 1; k++) do_tick();
        expect_v("R11 not yet", O_GS, 8'h00);
        do_tick();
        expect_v("R11 raised", O_GS, 8'h01);
        do_tick();
        expect_v("R11 held", O_GS, 8'h01);
        bus_idle = 1'b0;
        cyc();
        expect_v("R11 cleared", O_GS, 8'h00);

        repeat (3) cyc();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule